// File: doc/BRIEF.md
# Pipeline Hazard Stall Calculator

This block sits beside an in-order issue stage and works out how many bubble cycles each issued instruction must wait for. It keeps a three-instruction history of which registers recent instructions wrote. It also keeps a parallel three-level history of the registers filled by multi-register loads. When the issue logic presents a descriptor, the block checks the new instruction against that history and returns a stall count in the same cycle. The descriptor gives the instruction class flags, its source, destination-in and destination-out registers, the register span and base address of a block transfer, and the halfword position of the PC inside its 32-byte fetch line. On the next clock edge the history advances by one level for every bubble, with empty levels shifted in, and then by one more level for the instruction itself. Eight counters accumulate the bubbles charged to each hazard cause.

Register indices are five bits wide. Indices 0 to 15 are general registers and 16 to 31 are special registers. Two special-register positions hold markers instead of register state: bit 16 records "this instruction jumped" and bit 20 records "this instruction wrote memory". Index 23 is the multiply-overflow register. The history only moves when an instruction issues. Idle cycles leave it unchanged.

Top module: `hazard_stall_calc`

## Requirements
- R1: A synchronous active-high `rst` clears all history levels and all eight cause counters, so that an instruction issued after reset is charged no stall for anything issued before it.
- R2: For each of `srcReg` (when `srcValid`) and `dstInReg` (when `dstInValid`), checked in that order, a general register filled by a multi-register load costs 3 cycles if that load was the previous instruction, 2 if it was two back and 1 if it was three back. These cycles are counted in `cntLoadDep`.
- R3: Every bubble shifts both histories one level and inserts an empty level at the newest position, so a later hazard check in the same instruction sees its producers that much further back. Cycles with `issueValid` low do not advance the history.
- R4: An instruction with `usesAddrReg` set whose `srcReg` was written by the previous instruction costs 1 cycle (`cntAddrDep`).
- R5: An instruction with `isMemRead` set costs 2 cycles if either of the two previous instructions had `isMemWrite` set. The write is recorded in mask bit 20 (`cntReadAfterWrite`).
- R6: With `isJumpReg` set, `srcReg` costs 2 cycles if the previous instruction wrote it, else 1 cycle if the instruction two back wrote it (`cntJumpRegDep`). `isJump` sets marker bit 16.
- R7: When the previous instruction had `isJump` set, an instruction with `hasImm16` costs 1 cycle when `pcHalf` (PC bits [4:1]) equals 4'b1111. An instruction with `hasImm32` costs 1 cycle when `pcHalf` equals 4'b1110 (`cntJumpTarget`).
- R8: A multi-register store (`isMovemStore`) of general registers 0..`movemLast` costs 2 cycles if any of them was written by the previous instruction, else 1 cycle if any was written two back (`cntStoreSrcDep`).
- R9: A multi-register load or store costs 1 cycle for each 32-byte line beyond the first that is touched by the byte range `movemBase` to `movemBase + 4*(movemLast+1) - 1` (`cntLineCross`).
- R10: An instruction with `isMultiply` costs 1 cycle if `srcReg` or `dstInReg` was written by the previous instruction (`cntMulDep`). It marks register 23 as written.
- R11: A `dstOutReg` of 16 or 20 records no write, so it raises neither the jump nor the memory-write marker.
- R12: The causes are evaluated in the fixed order read-after-write, address source, jump target, jump register, multiply, store source, line crossing, load dependency. `stallCount` is their sum, is 0 while `issueValid` is low, and the counters change only on an issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueValid | input | 1 | A descriptor is presented and issues at the next edge |
| isMemRead | input | 1 | Instruction reads data memory |
| isMemWrite | input | 1 | Instruction writes data memory |
| usesAddrReg | input | 1 | `srcReg` supplies a memory address |
| hasImm16 | input | 1 | Instruction carries a 16-bit immediate |
| hasImm32 | input | 1 | Instruction carries a 32-bit immediate |
| isJump | input | 1 | Instruction changes flow (sets jump marker) |
| isJumpReg | input | 1 | Jump target comes from `srcReg` |
| isMultiply | input | 1 | Instruction uses the multiplier |
| isMovemLoad | input | 1 | Multi-register load of registers 0..`movemLast` |
| isMovemStore | input | 1 | Multi-register store of registers 0..`movemLast` |
| srcValid | input | 1 | `srcReg` is read by the execute stage |
| srcReg | input | 5 | Source register index |
| dstInValid | input | 1 | `dstInReg` is read by the execute stage |
| dstInReg | input | 5 | Destination register read as an operand |
| dstOutValid | input | 1 | `dstOutReg` is written |
| dstOutReg | input | 5 | Written register index |
| movemLast | input | 4 | Highest register of a multi-register transfer |
| movemBase | input | 32 | Byte base address of a multi-register transfer |
| pcHalf | input | 4 | PC bits [4:1] of the instruction |
| stallCount | output | 5 | Bubbles charged to the presented instruction |
| cntLoadDep | output | 16 | Bubbles from multi-register load dependencies |
| cntAddrDep | output | 16 | Bubbles from address-register dependencies |
| cntReadAfterWrite | output | 16 | Bubbles from memory read after write |
| cntJumpTarget | output | 16 | Bubbles from immediates at a jump target line end |
| cntJumpRegDep | output | 16 | Bubbles from jump-register dependencies |
| cntMulDep | output | 16 | Bubbles from multiply operand dependencies |
| cntStoreSrcDep | output | 16 | Bubbles from multi-register store sources |
| cntLineCross | output | 16 | Bubbles from 32-byte line crossings |

## Verification
The assertions check every cycle that no stall and no counter change appear without an issue. They also check that the total stays within its bound, and that back-to-back producer/consumer pairs (write then read of memory, register write then jump through it or multiply on it) are never charged less than the minimum those pairs require. The grading by distance and the way bubbles from an earlier cause push producers out of reach of a later cause can only be shown by the bench's scenarios. The same holds for the line-crossing arithmetic, the ignored marker positions and reset clearing the history. The bench's reference model follows the history level by level and is compared with the stall count and every counter on each issue.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int REG_IDX_W = 5;
  localparam int MASK_W = 1 << REG_IDX_W;
  localparam int GPR_N = MASK_W / 2;
  localparam int LIM_W = $clog2(GPR_N);
  localparam int JUMP_MARK = 16;
  localparam int MEMW_MARK = 20;
  localparam int MOF_REG = 23;
  localparam int LINE_SHIFT = 5;
  localparam int STALL_W = 5;
  localparam int AMT_W = 3;
  localparam int HIST_DEPTH = 3;
  localparam int NUM_CAUSE = 8;

  localparam int C_LOAD_DEP = 0;
  localparam int C_ADDR_DEP = 1;
  localparam int C_RAW = 2;
  localparam int C_JUMP_TGT = 3;
  localparam int C_JUMP_REG = 4;
  localparam int C_MUL_DEP = 5;
  localparam int C_STORE_SRC = 6;
  localparam int C_LINE_CROSS = 7;

  typedef struct packed {
    logic [MASK_W-1:0] h1;
    logic [MASK_W-1:0] h2;
    logic [MASK_W-1:0] h3;
    logic [GPR_N-1:0]  m1;
    logic [GPR_N-1:0]  m2;
    logic [GPR_N-1:0]  m3;
  } histT;

  typedef struct packed {
    logic                            commit;
    logic [STALL_W-1:0]              total;
    logic [NUM_CAUSE-1:0][AMT_W-1:0] amount;
    logic [MASK_W-1:0]               modfSet;
    logic [GPR_N-1:0]                loadSet;
  } strobeT;

  function automatic histT shiftHist(histT h, logic [STALL_W-1:0] n);
    histT r;
    r = h;
    for (int i = 0; i < HIST_DEPTH; i++) begin
      if (n > STALL_W'(i)) begin
        r.h3 = r.h2;
        r.h2 = r.h1;
        r.h1 = '0;
        r.m3 = r.m2;
        r.m2 = r.m1;
        r.m1 = '0;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
(
  input  logic                 issueValid,
  input  logic                 isMemRead,
  input  logic                 isMemWrite,
  input  logic                 usesAddrReg,
  input  logic                 hasImm16,
  input  logic                 hasImm32,
  input  logic                 isJump,
  input  logic                 isJumpReg,
  input  logic                 isMultiply,
  input  logic                 isMovemLoad,
  input  logic                 isMovemStore,
  input  logic                 srcValid,
  input  logic [REG_IDX_W-1:0] srcReg,
  input  logic                 dstInValid,
  input  logic [REG_IDX_W-1:0] dstInReg,
  input  logic                 dstOutValid,
  input  logic [REG_IDX_W-1:0] dstOutReg,
  input  logic [LIM_W-1:0]     movemLast,
  input  logic [MASK_W-1:0]    movemBase,
  input  logic [3:0]           pcHalf,
  input  histT                 histIn,
  output strobeT               strobe
);
  localparam int LINE_W = MASK_W - LINE_SHIFT;

  histT hs;
  logic [AMT_W-1:0] nRaw, nAddr, nTgt, nJreg, nMul, nStore, nLine, nLoadSrc, nLoadDin;
  logic [GPR_N-1:0] regRange;
  logic [MASK_W-1:0] spanEnd;
  logic [LINE_W-1:0] lineDiff;
  logic [MASK_W-1:0] modfSet;
  logic tgtHit;

  assign regRange = {GPR_N{1'b1}} >> (LIM_W'(GPR_N - 1) - movemLast);
  assign spanEnd  = movemBase + {{(MASK_W-LIM_W-2){1'b0}}, movemLast, 2'b11};
  assign lineDiff = spanEnd[MASK_W-1:LINE_SHIFT] - movemBase[MASK_W-1:LINE_SHIFT];
  assign tgtHit   = (hasImm16 && pcHalf == 4'b1111) || (hasImm32 && pcHalf == 4'b1110);

  always_comb begin
    hs = histIn;
    nRaw = '0; nAddr = '0; nTgt = '0; nJreg = '0; nMul = '0;
    nStore = '0; nLine = '0; nLoadSrc = '0; nLoadDin = '0;

    if (isMemRead && (hs.h1[MEMW_MARK] || hs.h2[MEMW_MARK])) nRaw = 3'd2;
    hs = shiftHist(hs, STALL_W'(nRaw));

    if (usesAddrReg && hs.h1[srcReg]) nAddr = 3'd1;
    hs = shiftHist(hs, STALL_W'(nAddr));

    if (tgtHit && hs.h1[JUMP_MARK]) nTgt = 3'd1;
    hs = shiftHist(hs, STALL_W'(nTgt));

    if (isJumpReg) begin
      if (hs.h1[srcReg])      nJreg = 3'd2;
      else if (hs.h2[srcReg]) nJreg = 3'd1;
    end
    hs = shiftHist(hs, STALL_W'(nJreg));

    if (isMultiply && (hs.h1[srcReg] || hs.h1[dstInReg])) nMul = 3'd1;
    hs = shiftHist(hs, STALL_W'(nMul));

    if (isMovemStore) begin
      if (|(hs.h1[GPR_N-1:0] & regRange))      nStore = 3'd2;
      else if (|(hs.h2[GPR_N-1:0] & regRange)) nStore = 3'd1;
    end
    hs = shiftHist(hs, STALL_W'(nStore));

    if (isMovemLoad || isMovemStore) nLine = {1'b0, lineDiff[1:0]};
    hs = shiftHist(hs, STALL_W'(nLine));

    if (srcValid && !srcReg[REG_IDX_W-1]) begin
      if (hs.m1[srcReg[LIM_W-1:0]])      nLoadSrc = 3'd3;
      else if (hs.m2[srcReg[LIM_W-1:0]]) nLoadSrc = 3'd2;
      else if (hs.m3[srcReg[LIM_W-1:0]]) nLoadSrc = 3'd1;
    end
    hs = shiftHist(hs, STALL_W'(nLoadSrc));

    if (dstInValid && !dstInReg[REG_IDX_W-1]) begin
      if (hs.m1[dstInReg[LIM_W-1:0]])      nLoadDin = 3'd3;
      else if (hs.m2[dstInReg[LIM_W-1:0]]) nLoadDin = 3'd2;
      else if (hs.m3[dstInReg[LIM_W-1:0]]) nLoadDin = 3'd1;
    end
  end

  always_comb begin
    modfSet = '0;
    if (dstOutValid && dstOutReg != REG_IDX_W'(JUMP_MARK) && dstOutReg != REG_IDX_W'(MEMW_MARK))
      modfSet[dstOutReg] = 1'b1;
    if (isJump)       modfSet[JUMP_MARK] = 1'b1;
    if (isMemWrite)   modfSet[MEMW_MARK] = 1'b1;
    if (isMultiply)   modfSet[MOF_REG] = 1'b1;
    if (isMovemLoad)  modfSet[GPR_N-1:0] = modfSet[GPR_N-1:0] | regRange;
  end

  always_comb begin
    strobe = '0;
    if (issueValid) begin
      strobe.commit = 1'b1;
      strobe.amount[C_RAW]        = nRaw;
      strobe.amount[C_ADDR_DEP]   = nAddr;
      strobe.amount[C_JUMP_TGT]   = nTgt;
      strobe.amount[C_JUMP_REG]   = nJreg;
      strobe.amount[C_MUL_DEP]    = nMul;
      strobe.amount[C_STORE_SRC]  = nStore;
      strobe.amount[C_LINE_CROSS] = nLine;
      strobe.amount[C_LOAD_DEP]   = nLoadSrc + nLoadDin;
      strobe.total = STALL_W'(nRaw) + STALL_W'(nAddr) + STALL_W'(nTgt) + STALL_W'(nJreg)
                   + STALL_W'(nMul) + STALL_W'(nStore) + STALL_W'(nLine)
                   + STALL_W'(nLoadSrc) + STALL_W'(nLoadDin);
      strobe.modfSet = modfSet;
      strobe.loadSet = isMovemLoad ? regRange : '0;
    end
  end
endmodule

// File: rtl/hazard_hist.sv
module hazard_hist
  import hazard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  strobeT                          strobe,
  output histT                            histOut,
  output logic [NUM_CAUSE-1:0][CNT_W-1:0] cntOut
);
  histT histQ;
  histT nextHist;

  always_comb begin
    nextHist = shiftHist(histQ, strobe.total);
    nextHist.h3 = nextHist.h2;
    nextHist.h2 = nextHist.h1;
    nextHist.h1 = strobe.modfSet;
    nextHist.m3 = nextHist.m2;
    nextHist.m2 = nextHist.m1;
    nextHist.m1 = strobe.loadSet;
  end

  always_ff @(posedge clk) begin
    if (rst)                histQ <= '0;
    else if (strobe.commit) histQ <= nextHist;
  end

  assign histOut = histQ;

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cnt
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (rst)                cntQ <= '0;
      else if (strobe.commit) cntQ <= cntQ + CNT_W'(strobe.amount[g]);
    end
    assign cntOut[g] = cntQ;
  end
endmodule

// File: rtl/hazard_stall_calc.sv
module hazard_stall_calc
  import hazard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issueValid,
  input  logic                 isMemRead,
  input  logic                 isMemWrite,
  input  logic                 usesAddrReg,
  input  logic                 hasImm16,
  input  logic                 hasImm32,
  input  logic                 isJump,
  input  logic                 isJumpReg,
  input  logic                 isMultiply,
  input  logic                 isMovemLoad,
  input  logic                 isMovemStore,
  input  logic                 srcValid,
  input  logic [REG_IDX_W-1:0] srcReg,
  input  logic                 dstInValid,
  input  logic [REG_IDX_W-1:0] dstInReg,
  input  logic                 dstOutValid,
  input  logic [REG_IDX_W-1:0] dstOutReg,
  input  logic [LIM_W-1:0]     movemLast,
  input  logic [MASK_W-1:0]    movemBase,
  input  logic [3:0]           pcHalf,
  output logic [STALL_W-1:0]   stallCount,
  output logic [CNT_W-1:0]     cntLoadDep,
  output logic [CNT_W-1:0]     cntAddrDep,
  output logic [CNT_W-1:0]     cntReadAfterWrite,
  output logic [CNT_W-1:0]     cntJumpTarget,
  output logic [CNT_W-1:0]     cntJumpRegDep,
  output logic [CNT_W-1:0]     cntMulDep,
  output logic [CNT_W-1:0]     cntStoreSrcDep,
  output logic [CNT_W-1:0]     cntLineCross
);
  strobeT strobe;
  histT hist;
  logic [NUM_CAUSE-1:0][CNT_W-1:0] cnt;

  hazard_ctrl u_ctrl (
    .issueValid(issueValid), .isMemRead(isMemRead), .isMemWrite(isMemWrite),
    .usesAddrReg(usesAddrReg), .hasImm16(hasImm16), .hasImm32(hasImm32),
    .isJump(isJump), .isJumpReg(isJumpReg), .isMultiply(isMultiply),
    .isMovemLoad(isMovemLoad), .isMovemStore(isMovemStore),
    .srcValid(srcValid), .srcReg(srcReg), .dstInValid(dstInValid), .dstInReg(dstInReg),
    .dstOutValid(dstOutValid), .dstOutReg(dstOutReg), .movemLast(movemLast),
    .movemBase(movemBase), .pcHalf(pcHalf), .histIn(hist), .strobe(strobe)
  );

  hazard_hist #(.CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst(rst), .strobe(strobe), .histOut(hist), .cntOut(cnt)
  );

  assign stallCount        = strobe.total;
  assign cntLoadDep        = cnt[C_LOAD_DEP];
  assign cntAddrDep        = cnt[C_ADDR_DEP];
  assign cntReadAfterWrite = cnt[C_RAW];
  assign cntJumpTarget     = cnt[C_JUMP_TGT];
  assign cntJumpRegDep     = cnt[C_JUMP_REG];
  assign cntMulDep         = cnt[C_MUL_DEP];
  assign cntStoreSrcDep    = cnt[C_STORE_SRC];
  assign cntLineCross      = cnt[C_LINE_CROSS];
endmodule

// File: rtl/hazard_stall_checker.sv
module hazard_stall_checker
  import hazard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 issueValid,
  input logic                 isMemRead,
  input logic                 isMemWrite,
  input logic                 isJumpReg,
  input logic                 isMultiply,
  input logic [REG_IDX_W-1:0] srcReg,
  input logic                 dstOutValid,
  input logic [REG_IDX_W-1:0] dstOutReg,
  input logic [STALL_W-1:0]   stallCount,
  input logic [CNT_W-1:0]     cntLoadDep,
  input logic [CNT_W-1:0]     cntAddrDep,
  input logic [CNT_W-1:0]     cntReadAfterWrite,
  input logic [CNT_W-1:0]     cntJumpTarget,
  input logic [CNT_W-1:0]     cntJumpRegDep,
  input logic [CNT_W-1:0]     cntMulDep,
  input logic [CNT_W-1:0]     cntStoreSrcDep,
  input logic [CNT_W-1:0]     cntLineCross
);
  logic prevRealWrite;
  assign prevRealWrite = dstOutValid && dstOutReg != REG_IDX_W'(JUMP_MARK)
                         && dstOutReg != REG_IDX_W'(MEMW_MARK);

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !issueValid |-> stallCount == '0);

  assert_counters_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !issueValid |=> $stable({cntLoadDep, cntAddrDep, cntReadAfterWrite, cntJumpTarget,
                             cntJumpRegDep, cntMulDep, cntStoreSrcDep, cntLineCross}));

  assert_stall_bound_R12: assert property (@(posedge clk) disable iff (rst)
    stallCount <= STALL_W'(17));

  assert_read_after_write_R5: assert property (@(posedge clk) disable iff (rst)
    (issueValid && isMemRead && $past(!rst && issueValid && isMemWrite))
    |-> stallCount >= STALL_W'(2));

  assert_jump_reg_dep_R6: assert property (@(posedge clk) disable iff (rst)
    (issueValid && isJumpReg && $past(!rst && issueValid && prevRealWrite)
     && $past(dstOutReg) == srcReg)
    |-> stallCount >= STALL_W'(2));

  assert_mul_dep_R10: assert property (@(posedge clk) disable iff (rst)
    (issueValid && isMultiply && $past(!rst && issueValid && prevRealWrite)
     && $past(dstOutReg) == srcReg)
    |-> stallCount >= STALL_W'(1));
endmodule

bind hazard_stall_calc hazard_stall_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/hazard_stall_calc_bench.sv
module hazard_stall_calc_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issueValid, isMemRead, isMemWrite, usesAddrReg, hasImm16, hasImm32;
  logic isJump, isJumpReg, isMultiply, isMovemLoad, isMovemStore;
  logic srcValid, dstInValid, dstOutValid;
  logic [4:0] srcReg, dstInReg, dstOutReg;
  logic [3:0] movemLast, pcHalf;
  logic [31:0] movemBase;
  logic [4:0] stallCount;
  logic [15:0] dutCnt [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_stall_calc u_hazard_stall_calc (
    .clk(clk), .rst(rst), .issueValid(issueValid), .isMemRead(isMemRead),
    .isMemWrite(isMemWrite), .usesAddrReg(usesAddrReg), .hasImm16(hasImm16),
    .hasImm32(hasImm32), .isJump(isJump), .isJumpReg(isJumpReg),
    .isMultiply(isMultiply), .isMovemLoad(isMovemLoad), .isMovemStore(isMovemStore),
    .srcValid(srcValid), .srcReg(srcReg), .dstInValid(dstInValid), .dstInReg(dstInReg),
    .dstOutValid(dstOutValid), .dstOutReg(dstOutReg), .movemLast(movemLast),
    .movemBase(movemBase), .pcHalf(pcHalf), .stallCount(stallCount),
    .cntLoadDep(dutCnt[0]), .cntAddrDep(dutCnt[1]), .cntReadAfterWrite(dutCnt[2]),
    .cntJumpTarget(dutCnt[3]), .cntJumpRegDep(dutCnt[4]), .cntMulDep(dutCnt[5]),
    .cntStoreSrcDep(dutCnt[6]), .cntLineCross(dutCnt[7])
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string causeReq [8] = '{"R2", "R4", "R5", "R7", "R6", "R10", "R8", "R9"};

  // Reference state: index 0 of each queue is the most recent instruction.
  bit [31:0] wrQ [$];
  bit [15:0] ldQ [$];
  int expCause [8];
  int expTotal;
  int expCnt [8];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    wrQ = '{0, 0, 0};
    ldQ = '{0, 0, 0};
    foreach (expCnt[i]) expCnt[i] = 0;
  endtask

  task automatic bubble(int n);
    repeat (n) begin
      wrQ.push_front(0); void'(wrQ.pop_back());
      ldQ.push_front(0); void'(ldQ.pop_back());
    end
  endtask

  task automatic charge(int cause, int n);
    expCause[cause] += n;
    expTotal += n;
    bubble(n);
  endtask

  function automatic int loadDist(int r);
    if (r >= 16) return 0;
    if (ldQ[0][r]) return 3;
    if (ldQ[1][r]) return 2;
    if (ldQ[2][r]) return 1;
    return 0;
  endfunction

  task automatic modelIssue();
    bit hit1, hit2;
    longint firstLine, lastLine;
    bit [31:0] nw;
    bit [15:0] nl;
    foreach (expCause[i]) expCause[i] = 0;
    expTotal = 0;
    if (isMemRead && (wrQ[0][20] || wrQ[1][20])) charge(2, 2);
    if (usesAddrReg && wrQ[0][srcReg]) charge(1, 1);
    if (wrQ[0][16] && ((hasImm16 && pcHalf == 4'hF) || (hasImm32 && pcHalf == 4'hE))) charge(3, 1);
    if (isJumpReg) begin
      if (wrQ[0][srcReg]) charge(4, 2);
      else if (wrQ[1][srcReg]) charge(4, 1);
    end
    if (isMultiply && (wrQ[0][srcReg] || wrQ[0][dstInReg])) charge(5, 1);
    if (isMovemStore) begin
      hit1 = 0; hit2 = 0;
      for (int r = 0; r <= int'(movemLast); r++) begin
        hit1 |= wrQ[0][r];
        hit2 |= wrQ[1][r];
      end
      if (hit1) charge(6, 2);
      else if (hit2) charge(6, 1);
    end
    if (isMovemLoad || isMovemStore) begin
      firstLine = longint'(movemBase) >> 5;
      lastLine = (longint'(movemBase) + 4 * (longint'(movemLast) + 1) - 1) >> 5;
      charge(7, int'(lastLine - firstLine));
    end
    if (srcValid) charge(0, loadDist(int'(srcReg)));
    if (dstInValid) charge(0, loadDist(int'(dstInReg)));
    nw = 0; nl = 0;
    if (dstOutValid && dstOutReg != 16 && dstOutReg != 20) nw[dstOutReg] = 1;
    if (isJump) nw[16] = 1;
    if (isMemWrite) nw[20] = 1;
    if (isMultiply) nw[23] = 1;
    if (isMovemLoad)
      for (int r = 0; r <= int'(movemLast); r++) begin nw[r] = 1; nl[r] = 1; end
    wrQ.push_front(nw); void'(wrQ.pop_back());
    ldQ.push_front(nl); void'(ldQ.pop_back());
    foreach (expCnt[i]) expCnt[i] += expCause[i];
  endtask

  task automatic clearDesc();
    issueValid = 0; isMemRead = 0; isMemWrite = 0; usesAddrReg = 0; hasImm16 = 0;
    hasImm32 = 0; isJump = 0; isJumpReg = 0; isMultiply = 0; isMovemLoad = 0;
    isMovemStore = 0; srcValid = 0; dstInValid = 0; dstOutValid = 0;
    srcReg = 0; dstInReg = 0; dstOutReg = 0; movemLast = 0; pcHalf = 0; movemBase = 0;
  endtask

  // Issues the descriptor currently set up. lit >= 0 also checks a hand-derived total.
  task automatic doIssue(string req, int lit);
    issueValid = 1;
    @(negedge clk);
    modelIssue();
    check(req, int'(stallCount), expTotal);
    if (lit >= 0) check(req, int'(stallCount), lit);
    @(posedge clk);
    #1;
    clearDesc();
    for (int c = 0; c < 8; c++) check(causeReq[c], int'(dutCnt[c]), expCnt[c]);
  endtask

  task automatic plain();
    doIssue("R12", 0);
  endtask

  task automatic writer(int r);
    dstOutValid = 1; dstOutReg = 5'(r);
  endtask

  task automatic doReset();
    rst = 1;
    repeat (2) @(posedge clk);
    #1;
    rst = 0;
    modelReset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clearDesc();
    modelReset();
    doReset();
    for (int c = 0; c < 8; c++) check("R1", int'(dutCnt[c]), 0);

    // R1: reset drops history left by earlier producers
    isMemWrite = 1; writer(5); doIssue("R5", 0);
    doReset();
    isJumpReg = 1; srcReg = 5; isMemRead = 1; doIssue("R1", 0);
    for (int c = 0; c < 8; c++) check("R1", int'(dutCnt[c]), 0);

    // R5: memory read after a write one or two back
    isMemWrite = 1; doIssue("R5", 0);
    isMemRead = 1; doIssue("R5", 2);
    isMemWrite = 1; doIssue("R5", 0);
    plain();
    isMemRead = 1; doIssue("R5", 2);
    isMemWrite = 1; doIssue("R5", 0);
    plain(); plain();
    isMemRead = 1; doIssue("R5", 0);

    // R4: address register written by the previous instruction only
    writer(3); doIssue("R4", 0);
    usesAddrReg = 1; srcReg = 3; doIssue("R4", 1);
    writer(3); doIssue("R4", 0);
    plain();
    usesAddrReg = 1; srcReg = 3; doIssue("R4", 0);

    // R6: jump through a register, graded 2 / 1 / 0
    writer(5); doIssue("R6", 0);
    isJumpReg = 1; isJump = 1; srcReg = 5; doIssue("R6", 2);
    writer(5); doIssue("R6", 0);
    plain();
    isJumpReg = 1; srcReg = 5; doIssue("R6", 1);
    writer(5); doIssue("R6", 0);
    plain(); plain();
    isJumpReg = 1; srcReg = 5; doIssue("R6", 0);

    // R7: immediates at the end of a jump target line
    isJump = 1; doIssue("R7", 0);
    hasImm16 = 1; pcHalf = 4'hF; doIssue("R7", 1);
    isJump = 1; doIssue("R7", 0);
    hasImm32 = 1; pcHalf = 4'hE; doIssue("R7", 1);
    isJump = 1; doIssue("R7", 0);
    hasImm16 = 1; pcHalf = 4'hE; doIssue("R7", 0);
    hasImm16 = 1; pcHalf = 4'hF; doIssue("R7", 0);

    // R8: store of registers 0..3 against recent writes
    writer(2); doIssue("R8", 0);
    isMovemStore = 1; movemLast = 3; doIssue("R8", 2);
    writer(2); doIssue("R8", 0);
    plain();
    isMovemStore = 1; movemLast = 3; doIssue("R8", 1);
    writer(5); doIssue("R8", 0);
    isMovemStore = 1; movemLast = 3; doIssue("R8", 0);

    // R9: line crossings of the transfer range
    plain(); plain();
    isMovemStore = 1; movemLast = 7; movemBase = 32'h40; doIssue("R9", 0);
    isMovemStore = 1; movemLast = 7; movemBase = 32'h44; doIssue("R9", 1);
    isMovemStore = 1; movemLast = 15; movemBase = 32'h1C; doIssue("R9", 2);
    isMovemLoad = 1; movemLast = 0; movemBase = 32'h1E; doIssue("R9", 1);
    plain(); plain(); plain();

    // R2: dependence on a multi-register load, by distance
    isMovemLoad = 1; movemLast = 3; doIssue("R2", 0);
    srcValid = 1; srcReg = 2; doIssue("R2", 3);
    isMovemLoad = 1; movemLast = 3; doIssue("R2", 0);
    plain();
    srcValid = 1; srcReg = 2; doIssue("R2", 2);
    isMovemLoad = 1; movemLast = 3; doIssue("R2", 0);
    plain(); plain();
    dstInValid = 1; dstInReg = 1; doIssue("R2", 1);
    isMovemLoad = 1; movemLast = 3; doIssue("R2", 0);
    plain(); plain(); plain();
    srcValid = 1; srcReg = 2; doIssue("R2", 0);

    // R3: bubbles of the first check push the second producer out of reach
    isMovemLoad = 1; movemLast = 1; doIssue("R3", 0);
    srcValid = 1; srcReg = 0; dstInValid = 1; dstInReg = 1; doIssue("R3", 3);
    isMemWrite = 1; writer(7); doIssue("R3", 0);
    isMemRead = 1; usesAddrReg = 1; srcReg = 7; doIssue("R3", 2);
    isMemWrite = 1; writer(6); doIssue("R3", 0);
    isMemRead = 1; isJumpReg = 1; srcReg = 6; doIssue("R3", 2);
    // R3: idle cycles do not age the history
    writer(5); doIssue("R3", 0);
    repeat (5) begin
      @(negedge clk);
      check("R12", int'(stallCount), 0);
      @(posedge clk); #1;
    end
    isJumpReg = 1; srcReg = 5; doIssue("R3", 2);

    // R10: multiply operands and the overflow register
    writer(4); doIssue("R10", 0);
    isMultiply = 1; srcReg = 4; dstInReg = 9; writer(9); doIssue("R10", 1);
    isMultiply = 1; srcReg = 1; dstInReg = 9; doIssue("R10", 1);
    isJumpReg = 1; srcReg = 23; doIssue("R10", 2);
    writer(4); doIssue("R10", 0);
    plain();
    isMultiply = 1; srcReg = 4; dstInReg = 8; doIssue("R10", 0);

    // R11: writes to the marker positions are not recorded
    plain(); plain();
    writer(20); doIssue("R11", 0);
    isMemRead = 1; doIssue("R11", 0);
    writer(16); doIssue("R11", 0);
    hasImm16 = 1; pcHalf = 4'hF; doIssue("R11", 0);
    writer(20); doIssue("R11", 0);
    isJumpReg = 1; srcReg = 20; doIssue("R11", 0);

    // R12: mixed traffic against the reference model
    for (int n = 0; n < 400; n++) begin
      int kind;
      kind = int'($urandom_range(0, 7));
      srcValid = 1'($urandom_range(0, 1)); srcReg = 5'($urandom_range(0, 7));
      dstInValid = 1'($urandom_range(0, 1)); dstInReg = 5'($urandom_range(0, 7));
      dstOutValid = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 9))
        0: dstOutReg = 5'd16;
        1: dstOutReg = 5'd20;
        2: dstOutReg = 5'd23;
        default: dstOutReg = 5'($urandom_range(0, 7));
      endcase
      pcHalf = 4'($urandom_range(12, 15));
      movemLast = 4'($urandom_range(0, 15));
      movemBase = 32'($urandom_range(0, 255));
      case (kind)
        1: begin isMemRead = 1; usesAddrReg = 1; end
        2: begin isMemWrite = 1; usesAddrReg = 1; end
        3: begin isJumpReg = 1; isJump = 1; end
        4: if ($urandom_range(0, 1) == 1) hasImm16 = 1; else hasImm32 = 1;
        5: isMultiply = 1;
        6: isMovemStore = 1;
        7: isMovemLoad = 1;
        default: isJump = 1'($urandom_range(0, 3) == 0);
      endcase
      doIssue("R12", -1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule